// File: doc/BRIEF.md
# Eight-Way Tree Pseudo-LRU Replacement Controller

This block holds the replacement history of an 8-way set-associative cache as seven tree bits per set. The number of sets is a parameter. A binary decision tree over those bits names the way to evict in a set chosen on the lookup index. A hit or a line fill marks the touched way as most recently used by rewriting three bits of the tree. Accesses that come from snoops do not change the history.

The cache controller drives a set index and a way number with an access strobe whenever a way is hit or reloaded. It raises a snoop qualifier alongside the strobe for coherence traffic. On a miss it reads the victim way for the lookup index. Tags, data, valid bits and the choice of an empty way to fill all live outside the block.

The block has no state machine. Its only sequential element is one seven-bit register per set. Each register has two transitions: a clear on reset, and a masked three-bit write on a qualifying access. Every other cycle it holds its value.

Top module: `plru8_tree_ctrl`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every set's seven bits are cleared. From the next cycle every in-range lookup reports way 0.
- R2: The victim comes from the tree bits of the looked-up set. Bit k of a row is node Bk. The walk reads B0 first: 0 leads to B1 and 1 leads to B2. Below B1 is leaf B3 (ways 0/1) when B1=0, or leaf B4 (ways 2/3) when B1=1. Below B2 is leaf B5 (ways 4/5) when B2=0, or leaf B6 (ways 6/7) when B2=1. A leaf value of 0 picks the lower-numbered way of its pair.
- R3: A qualifying access to a way in the lower half (`acc_way[2]`=0) writes B0=1. It writes B1 = NOT `acc_way[1]`. It writes the leaf B3 (ways 0/1) or B4 (ways 2/3) as NOT `acc_way[0]`.
- R4: A qualifying access to a way in the upper half (`acc_way[2]`=1) writes B0=0. It writes B2 = NOT `acc_way[1]`. It writes the leaf B5 (ways 4/5) or B6 (ways 6/7) as NOT `acc_way[0]`.
- R5: Each qualifying access writes exactly three bits of one set. The other four bits of that set, and all other sets, keep their values.
- R6: A strobe with `acc_snoop` high changes no stored bit.
- R7: An update takes effect at the clock edge that samples the strobe. A lookup of the same set in the strobe cycle reports the victim from before the update.
- R8: Reset wins over an access strobe in the same cycle.
- R9: A set index of `SET_COUNT` or above is ignored on the update side. On the lookup side it reports way 0.
- R10: After all eight ways of a set are touched in any order, the victim is the way touched first, provided the order visits the tree as 0,4,2,6,1,5,3,7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | Access strobe (hit or reload) |
| acc_snoop | input | 1 | Access comes from a snoop; no update |
| acc_set | input | IDX_W | Set index of the access |
| acc_way | input | 3 | Way number of the access |
| look_set | input | IDX_W | Set index for the victim lookup |
| victim_way | output | 3 | Victim way of `look_set` (combinational) |

## Verification
The assertions assume that `acc_way` is always a defined 3-bit value while the strobe is high. They also assume that the checker's own record of the last update is reset together with the block, so its first comparison follows a real access. The bench drives every input at the falling edge with defined values. It never leaves the strobe asserted across a reset release except in the reset-priority test, and it reaches the out-of-range index only through explicit directed steps.

// File: rtl/plru8_pkg.sv
package plru8_pkg;
    localparam int WAYS      = 8;
    localparam int WAY_W     = $clog2(WAYS);
    localparam int TREE_BITS = WAYS - 1;

    typedef logic [WAY_W-1:0]     way_t;
    typedef logic [TREE_BITS-1:0] tree_t;
endpackage

// File: rtl/plru8_touch_decode.sv
module plru8_touch_decode
    import plru8_pkg::*;
(
    input  way_t  way,
    output tree_t wr_mask,
    output tree_t wr_val
);
    logic [2:0] mid_node;
    logic [2:0] leaf_node;

    always_comb begin
        mid_node  = 3'd1 + {2'b00, way[2]};
        leaf_node = 3'd3 + {1'b0, way[2:1]};
        wr_mask   = '0;
        wr_val    = '0;
        wr_mask[0]         = 1'b1;
        wr_val[0]          = ~way[2];
        wr_mask[mid_node]  = 1'b1;
        wr_val[mid_node]   = ~way[1];
        wr_mask[leaf_node] = 1'b1;
        wr_val[leaf_node]  = ~way[0];
    end
endmodule

// File: rtl/plru8_victim_walk.sv
module plru8_victim_walk
    import plru8_pkg::*;
(
    input  tree_t row,
    output way_t  victim
);
    logic [2:0] mid_node;
    logic [2:0] leaf_node;
    logic       go_upper;
    logic       go_right;

    always_comb begin
        go_upper  = row[0];
        mid_node  = 3'd1 + {2'b00, go_upper};
        go_right  = row[mid_node];
        leaf_node = 3'd3 + {1'b0, go_upper, go_right};
        victim    = {go_upper, go_right, row[leaf_node]};
    end
endmodule

// File: rtl/plru8_state_bank.sv
module plru8_state_bank
    import plru8_pkg::*;
#(
    parameter int SET_COUNT = 48,
    parameter int IDX_W     = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [IDX_W-1:0]                  wr_set,
    input  tree_t                             wr_mask,
    input  tree_t                             wr_val,
    output logic [SET_COUNT-1:0][TREE_BITS-1:0] rows_q
);
    for (genvar s = 0; s < SET_COUNT; s++) begin : g_set
        tree_t row_r;
        logic  sel;

        assign sel = wr_en && (wr_set == IDX_W'(s));

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_r <= '0;
            end else if (sel) begin
                row_r <= (row_r & ~wr_mask) | (wr_val & wr_mask);
            end
        end

        assign rows_q[s] = row_r;
    end
endmodule

// File: rtl/plru8_tree_ctrl.sv
module plru8_tree_ctrl
    import plru8_pkg::*;
#(
    parameter int SET_COUNT = 48,
    parameter int IDX_W     = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_valid,
    input  logic             acc_snoop,
    input  logic [IDX_W-1:0] acc_set,
    input  logic [2:0]       acc_way,
    input  logic [IDX_W-1:0] look_set,
    output logic [2:0]       victim_way
);
    localparam logic [IDX_W:0] SET_LIMIT = (IDX_W+1)'(SET_COUNT);

    logic                               acc_in_range;
    logic                               look_in_range;
    logic                               upd_en;
    tree_t                              upd_mask;
    tree_t                              upd_val;
    tree_t                              look_row;
    way_t                               walk_way;
    logic [SET_COUNT-1:0][TREE_BITS-1:0] rows_q;

    assign acc_in_range  = {1'b0, acc_set}  < SET_LIMIT;
    assign look_in_range = {1'b0, look_set} < SET_LIMIT;
    assign upd_en        = acc_valid && !acc_snoop && acc_in_range;

    plru8_touch_decode u_touch (
        .way     (acc_way),
        .wr_mask (upd_mask),
        .wr_val  (upd_val)
    );

    plru8_state_bank #(
        .SET_COUNT (SET_COUNT),
        .IDX_W     (IDX_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (upd_en),
        .wr_set  (acc_set),
        .wr_mask (upd_mask),
        .wr_val  (upd_val),
        .rows_q  (rows_q)
    );

    always_comb begin
        look_row = '0;
        if (look_in_range) begin
            look_row = rows_q[look_set];
        end
    end

    plru8_victim_walk u_walk (
        .row    (look_row),
        .victim (walk_way)
    );

    assign victim_way = walk_way;
endmodule

// File: rtl/plru8_tree_ctrl_chk.sv
module plru8_tree_ctrl_chk
    import plru8_pkg::*;
#(
    parameter int SET_COUNT = 48,
    parameter int IDX_W     = 6
) (
    input logic                               clk,
    input logic                               rst_n,
    input logic                               acc_valid,
    input logic                               acc_snoop,
    input logic [IDX_W-1:0]                   acc_set,
    input logic [2:0]                         acc_way,
    input logic [2:0]                         victim_way,
    input logic [SET_COUNT-1:0][TREE_BITS-1:0] rows_q
);
    localparam logic [IDX_W:0] SET_LIMIT = (IDX_W+1)'(SET_COUNT);

    logic             range_ok;
    logic             prev_upd;
    logic [IDX_W-1:0] prev_set;
    way_t             prev_way;
    tree_t            prev_row;

    assign range_ok = {1'b0, acc_set} < SET_LIMIT;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_upd <= 1'b0;
            prev_set <= '0;
            prev_way <= '0;
            prev_row <= '0;
        end else begin
            prev_upd <= acc_valid && !acc_snoop && range_ok;
            prev_set <= acc_set;
            prev_way <= acc_way;
            prev_row <= range_ok ? rows_q[acc_set] : '0;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (rows_q == '0) && (victim_way == 3'd0));

    // R6
    snoop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_snoop) |=> $stable(rows_q));

    // R9
    range_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !range_ok) |=> $stable(rows_q));

    // R5
    three_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prev_upd |-> ($countones(rows_q[prev_set] ^ prev_row) <= 3));

    // R3 R4
    root_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prev_upd |-> (rows_q[prev_set][0] == ~prev_way[2]));
endmodule

bind plru8_tree_ctrl plru8_tree_ctrl_chk #(
    .SET_COUNT (SET_COUNT),
    .IDX_W     (IDX_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .acc_snoop  (acc_snoop),
    .acc_set    (acc_set),
    .acc_way    (acc_way),
    .victim_way (victim_way),
    .rows_q     (rows_q)
);

// File: tb/test_plru8_tree_ctrl.sv
`timescale 1ns/1ps
module test_plru8_tree_ctrl;
    localparam int SET_COUNT = 48;
    localparam int IDX_W     = 6;
    localparam int NVEC      = 11;

    typedef struct packed {
        logic [5:0] set;
        logic [2:0] way;
        logic       snoop;
        logic [2:0] exp;
    } vec_t;

    // Walk of set 3 in order 0,4,2,6,1,5(snoop),5,3,7, then set 5.
    localparam vec_t VECS [0:NVEC-1] = '{
        '{6'd3, 3'd0, 1'b0, 3'd4},
        '{6'd3, 3'd4, 1'b0, 3'd2},
        '{6'd3, 3'd2, 1'b0, 3'd6},
        '{6'd3, 3'd6, 1'b0, 3'd1},
        '{6'd3, 3'd1, 1'b0, 3'd5},
        '{6'd3, 3'd5, 1'b1, 3'd5},
        '{6'd3, 3'd5, 1'b0, 3'd3},
        '{6'd3, 3'd3, 1'b0, 3'd7},
        '{6'd3, 3'd7, 1'b0, 3'd0},
        '{6'd5, 3'd7, 1'b0, 3'd0},
        '{6'd5, 3'd3, 1'b0, 3'd4}
    };

    logic             clk = 1'b0;
    logic             rst_n;
    logic             acc_valid;
    logic             acc_snoop;
    logic [IDX_W-1:0] acc_set;
    logic [2:0]       acc_way;
    logic [IDX_W-1:0] look_set;
    logic [2:0]       victim_way;

    int checks = 0;
    int errors = 0;
    logic [6:0] model [0:SET_COUNT-1];

    always #2 clk = ~clk;

    plru8_tree_ctrl #(.SET_COUNT(SET_COUNT), .IDX_W(IDX_W)) i_plru8_tree_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .acc_snoop  (acc_snoop),
        .acc_set    (acc_set),
        .acc_way    (acc_way),
        .look_set   (look_set),
        .victim_way (victim_way)
    );

    task automatic model_clear();
        for (int s = 0; s < SET_COUNT; s++) model[s] = 7'd0;
    endtask

    // Table of written bits per way (R3, R4); bit k is Bk.
    task automatic model_touch(input int s, input logic [2:0] w);
        case (w)
            3'd0: begin model[s][0] = 1; model[s][1] = 1; model[s][3] = 1; end
            3'd1: begin model[s][0] = 1; model[s][1] = 1; model[s][3] = 0; end
            3'd2: begin model[s][0] = 1; model[s][1] = 0; model[s][4] = 1; end
            3'd3: begin model[s][0] = 1; model[s][1] = 0; model[s][4] = 0; end
            3'd4: begin model[s][0] = 0; model[s][2] = 1; model[s][5] = 1; end
            3'd5: begin model[s][0] = 0; model[s][2] = 1; model[s][5] = 0; end
            3'd6: begin model[s][0] = 0; model[s][2] = 0; model[s][6] = 1; end
            default: begin model[s][0] = 0; model[s][2] = 0; model[s][6] = 0; end
        endcase
    endtask

    // Decision tree (R2).
    function automatic logic [2:0] model_victim(input logic [6:0] b);
        if (!b[0]) begin
            if (!b[1]) return b[3] ? 3'd1 : 3'd0;
            else       return b[4] ? 3'd3 : 3'd2;
        end else begin
            if (!b[2]) return b[5] ? 3'd5 : 3'd4;
            else       return b[6] ? 3'd7 : 3'd6;
        end
    endfunction

    task automatic chk(input string req, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic look(input int s, output logic [2:0] v);
        look_set = IDX_W'(s);
        #1;
        v = victim_way;
    endtask

    task automatic access(input int s, input logic [2:0] w, input logic snp);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_set   = IDX_W'(s);
        acc_way   = w;
        acc_snoop = snp;
        @(negedge clk);
        acc_valid = 1'b0;
        acc_snoop = 1'b0;
        if (!snp && s < SET_COUNT) model_touch(s, w);
    endtask

    task automatic check_all_sets(input string req);
        logic [2:0] v;
        for (int s = 0; s < SET_COUNT; s++) begin
            look(s, v);
            chk(req, v, model_victim(model[s]));
        end
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] v;
        rst_n     = 1'b0;
        acc_valid = 1'b0;
        acc_snoop = 1'b0;
        acc_set   = '0;
        acc_way   = '0;
        look_set  = '0;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: every set reports way 0 after reset
        check_all_sets("R1 reset victim");

        // R9: out-of-range lookup reports way 0
        look(50, v);
        chk("R9 lookup out of range", v, 3'd0);

        // R2 R3 R4 R5 R6 R10: vector table against table and model
        for (int i = 0; i < NVEC; i++) begin
            access(int'(VECS[i].set), VECS[i].way, VECS[i].snoop);
            look(int'(VECS[i].set), v);
            chk($sformatf("R2 R3 R4 R5 R10 vector %0d", i), v, VECS[i].exp);
            chk($sformatf("R2 model vector %0d", i), v, model_victim(model[VECS[i].set]));
        end

        // R7: same-cycle lookup sees old state, new one after the edge
        @(negedge clk);
        acc_valid = 1'b1;
        acc_snoop = 1'b0;
        acc_set   = IDX_W'(9);
        acc_way   = 3'd0;
        look(9, v);
        chk("R7 old state in strobe cycle", v, 3'd0);
        @(negedge clk);
        acc_valid = 1'b0;
        model_touch(9, 3'd0);
        look(9, v);
        chk("R7 new state after edge", v, 3'd4);

        // R9: out-of-range update touches no set
        access(50, 3'd0, 1'b0);
        access(63, 3'd5, 1'b0);
        check_all_sets("R9 update out of range");
        look(63, v);
        chk("R9 lookup 63", v, 3'd0);

        // R6: snoops of every way on a used set change nothing
        for (int w = 0; w < 8; w++) access(9, 3'(w), 1'b1);
        for (int w = 0; w < 8; w++) access(3, 3'(w), 1'b1);
        check_all_sets("R6 snoop ignored");

        // R5: partial updates keep other bits (mixing halves on set 12)
        access(12, 3'd6, 1'b0);
        access(12, 3'd2, 1'b0);
        access(12, 3'd5, 1'b0);
        look(12, v);
        chk("R5 untouched bits kept", v, 3'd0);
        check_all_sets("R5 other sets kept");

        // R8: reset wins over a same-cycle strobe
        @(negedge clk);
        rst_n     = 1'b0;
        acc_valid = 1'b1;
        acc_set   = IDX_W'(9);
        acc_way   = 3'd4;
        @(negedge clk);
        rst_n     = 1'b1;
        acc_valid = 1'b0;
        model_clear();
        look(9, v);
        chk("R8 reset priority set 9", v, 3'd0);
        look(3, v);
        chk("R8 reset clears set 3", v, 3'd0);
        check_all_sets("R1 R8 all sets cleared");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule